// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block converts a 32-bit linear address into a physical address by reading two levels of translation tables from memory. A requester presents the linear address together with a read/write flag, and a root register supplies the physical base of the top-level table. The block reads one top-level word, which points at a second-level table. It then reads one second-level word, which names a 4 KiB physical frame. It returns the frame joined to the unchanged page offset, or it returns a fault code.

The linear address has three fields. Bits 31:22 index the top-level table, bits 21:12 index the second-level table, and bits 11:0 are the offset inside the page. Every table word has the same layout: bit 0 marks the word as present, bit 1 grants write permission, and bits 31:12 carry the next physical base. All other bits are ignored. The block keeps at most one memory read in flight. It accepts a new request only while idle, and it holds each result until the requester acknowledges it.

Top module: `pgwalk`

## Requirements
- R1: The first memory read address is the root register plus four times the top-level index (linear bits 31:22), computed as a full 32-bit sum.
- R2: The second memory read address is {top-level word bits 31:12, linear bits 21:12, 2'b00}.
- R3: If the top-level word has bit 0 clear, the result is fault code 1 (not present), and the walk makes exactly one memory read.
- R4: If the second-level word has bit 0 clear, the result is fault code 1.
- R5: If the second-level word has bit 1 clear, a read request completes with code 0, while a write request gets code 2 (protection). Any nonzero code returns a physical address of 0, and code 3 never appears.
- R6: A successful result is {second-level word bits 31:12, linear bits 11:0}. Word bits 11:2 are ignored at both levels, and bit 1 of the top-level word is ignored.
- R7: At most one memory read is outstanding at a time. A read request stays asserted with a stable address until it is accepted, and it is never asserted while a response is returning.
- R8: req_ready is high only in idle. A request presented while a walk is in progress is ignored.
- R9: res_valid, res_paddr and res_fault hold steady until res_ready is seen. The block then returns to idle in the next cycle.
- R10: After reset, req_ready is 1 and res_valid and mem_req_valid are 0.
- R11: A walk with a present top-level word makes exactly two memory reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| root_base | input | 32 | Physical base of the top-level table |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returning |
| mem_rsp_data | input | 32 | Read data word |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result acknowledged |
| res_paddr | output | 32 | Physical address, 0 on fault |
| res_fault | output | 2 | 0 ok, 1 not present, 2 protection |

## Verification
A corrupted walk state shows up at the memory port within one or two cycles. The access count changes, the second address is wrong, or a read request appears while a response is still outstanding. A corrupted latched address or latched entry shows up only when the result is presented, as a wrong frame, a wrong offset or a wrong fault code. The bench sweeps every top-level index, issuing both a read and a write against each one. It stalls the memory port and varies its latency. Each walk is checked for access count, each access address, the final result and the handshake behaviour.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ROOT_REQ = 3'd1,
    ST_ROOT_RSP = 3'd2,
    ST_LEAF_REQ = 3'd3,
    ST_LEAF_RSP = 3'd4,
    ST_DONE     = 3'd5
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PROT   = 2'd2
  } fault_e;

  localparam int unsigned PRESENT_BIT  = 0;
  localparam int unsigned WRITABLE_BIT = 1;

endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic [ADDR_W-1:0]        vaddr,
  input  logic [ADDR_W-1:0]        root_base,
  input  logic [ADDR_W-OFF_W-1:0]  leaf_base,
  input  logic                     leaf_level,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [OFF_W-1:0]         page_off
);
  localparam int unsigned SLOT_SH = OFF_W - IDX_W;

  logic [IDX_W-1:0]  top_idx;
  logic [IDX_W-1:0]  sub_idx;
  logic [ADDR_W-1:0] top_slot;
  logic [ADDR_W-1:0] root_addr;
  logic [ADDR_W-1:0] leaf_addr;

  assign top_idx   = vaddr[ADDR_W-1 -: IDX_W];
  assign sub_idx   = vaddr[OFF_W +: IDX_W];
  assign page_off  = vaddr[OFF_W-1:0];
  assign top_slot  = {{(ADDR_W-IDX_W){1'b0}}, top_idx} << SLOT_SH;
  assign root_addr = root_base + top_slot;
  assign leaf_addr = {leaf_base, sub_idx, {SLOT_SH{1'b0}}};
  assign mem_addr  = leaf_level ? leaf_addr : root_addr;
endmodule

// File: rtl/pgwalk_judge.sv
module pgwalk_judge
  import pgwalk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic [ADDR_W-1:0]       word,
  input  logic                    leaf_level,
  input  logic                    is_write,
  output fault_e                  fault,
  output logic [ADDR_W-OFF_W-1:0] frame
);
  logic present;
  logic writable;

  assign present  = word[PRESENT_BIT];
  assign writable = word[WRITABLE_BIT];
  assign frame    = word[ADDR_W-1:OFF_W];

  always_comb begin
    if (!present)                            fault = FLT_ABSENT;
    else if (leaf_level && is_write && !writable) fault = FLT_PROT;
    else                                     fault = FLT_NONE;
  end
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_vaddr,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       root_base,
  input  logic                    mem_req_ready,
  input  logic                    mem_rsp_valid,
  input  fault_e                  judge_fault,
  input  logic [ADDR_W-OFF_W-1:0] judge_frame,
  input  logic [OFF_W-1:0]        page_off,
  input  logic                    res_ready,
  output logic [ADDR_W-1:0]       vaddr_q,
  output logic [ADDR_W-1:0]       root_q,
  output logic                    write_q,
  output logic [ADDR_W-OFF_W-1:0] leaf_base_q,
  output logic                    leaf_level,
  output logic                    req_ready,
  output logic                    mem_req_valid,
  output logic                    res_valid,
  output logic [ADDR_W-1:0]       res_paddr,
  output logic [1:0]              res_fault
);
  walk_state_e st_q, st_d;
  logic        cap_en, leaf_en, res_en;
  fault_e      fault_q, fault_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;

  always_comb begin
    st_d    = st_q;
    cap_en  = 1'b0;
    leaf_en = 1'b0;
    res_en  = 1'b0;
    fault_d = judge_fault;
    paddr_d = '0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d   = ST_ROOT_REQ;
        cap_en = 1'b1;
      end
      ST_ROOT_REQ: if (mem_req_ready) st_d = ST_ROOT_RSP;
      ST_ROOT_RSP: if (mem_rsp_valid) begin
        if (judge_fault != FLT_NONE) begin
          st_d   = ST_DONE;
          res_en = 1'b1;
        end else begin
          st_d    = ST_LEAF_REQ;
          leaf_en = 1'b1;
        end
      end
      ST_LEAF_REQ: if (mem_req_ready) st_d = ST_LEAF_RSP;
      ST_LEAF_RSP: if (mem_rsp_valid) begin
        st_d   = ST_DONE;
        res_en = 1'b1;
        if (judge_fault == FLT_NONE) paddr_d = {judge_frame, page_off};
      end
      ST_DONE: if (res_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q <= '0;
      root_q  <= '0;
      write_q <= 1'b0;
    end else if (cap_en) begin
      vaddr_q <= req_vaddr;
      root_q  <= root_base;
      write_q <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      leaf_base_q <= '0;
    else if (leaf_en) leaf_base_q <= judge_frame;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= FLT_NONE;
      paddr_q <= '0;
    end else if (res_en) begin
      fault_q <= fault_d;
      paddr_q <= paddr_d;
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_ROOT_REQ) || (st_q == ST_LEAF_REQ);
  assign leaf_level    = (st_q == ST_LEAF_REQ) || (st_q == ST_LEAF_RSP);
  assign res_valid     = (st_q == ST_DONE);
  assign res_paddr     = paddr_q;
  assign res_fault     = fault_q;

  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid);
  // R7
  one_inflight_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_rsp_valid |-> !mem_req_valid);
  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr) && $stable(res_fault)));
  // R9
  res_release_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (res_valid && res_ready) |=> req_ready);
  // R8
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(req_ready && (res_valid || mem_req_valid)));
  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (res_valid && res_fault != 2'd0) |-> (res_paddr == '0));
  // R5
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    res_valid |-> (res_fault != 2'd3));
endmodule

// File: rtl/pgwalk.sv
module pgwalk
  import pgwalk_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] root_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_paddr,
  output logic [1:0]        res_fault
);
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [ADDR_W-1:0]  vaddr_q, root_q;
  logic               write_q, leaf_level;
  logic [FRAME_W-1:0] leaf_base_q, judge_frame;
  logic [OFF_W-1:0]   page_off;
  fault_e             judge_fault;

  pgwalk_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .vaddr      (vaddr_q),
    .root_base  (root_q),
    .leaf_base  (leaf_base_q),
    .leaf_level (leaf_level),
    .mem_addr   (mem_req_addr),
    .page_off   (page_off)
  );

  pgwalk_judge #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_judge (
    .word       (mem_rsp_data),
    .leaf_level (leaf_level),
    .is_write   (write_q),
    .fault      (judge_fault),
    .frame      (judge_frame)
  );

  pgwalk_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fsm (
    .clk           (clk),
    .rst_ni        (rst_sync),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .root_base     (root_base),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .judge_fault   (judge_fault),
    .judge_frame   (judge_frame),
    .page_off      (page_off),
    .res_ready     (res_ready),
    .vaddr_q       (vaddr_q),
    .root_q        (root_q),
    .write_q       (write_q),
    .leaf_base_q   (leaf_base_q),
    .leaf_level    (leaf_level),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .res_valid     (res_valid),
    .res_paddr     (res_paddr),
    .res_fault     (res_fault)
  );

  // R7
  mem_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));
endmodule

// File: tb/pgwalk_test.sv
`timescale 1ns/1ps
module pgwalk_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0, root_base = '0;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_ready = 1'b0;
  logic        req_ready, mem_req_valid, res_valid;
  logic [31:0] mem_req_addr, res_paddr;
  logic [1:0]  res_fault;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  pgwalk uut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] root_word(input logic [9:0] d);
    return {20'h00100 + {10'd0, d}, d ^ 10'h2AA, d[1], (d % 4) != 0};
  endfunction

  function automatic logic [31:0] leaf_word(input logic [31:0] a);
    logic [19:0] t = a[31:12];
    logic [9:0]  i = a[11:2];
    return {(t * 20'd3 + {10'd0, i}) ^ 20'h5A5A5, i ^ 10'h155, i[1], (i % 5) != 0};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] rel = a - root_base;
    if (rel < 32'd4096) return root_word(rel[11:2]);
    return leaf_word(a);
  endfunction

  // memory model: stalls and variable latency, logs accesses
  int acc_cnt = 0, overlap = 0, wait_cnt = 0;
  bit busy = 0, accepted = 0;
  logic [31:0] pend_addr, acc_log [4];
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (accepted) begin
      accepted = 0; busy = 1; wait_cnt = cyc % 3;
    end
    if (busy && mem_req_valid) overlap++;
    if (busy) begin
      if (wait_cnt == 0) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = mem_word(pend_addr); busy = 0;
      end else wait_cnt--;
    end
    mem_req_ready = !busy && ((cyc % 4) != 1);
    if (mem_req_ready && mem_req_valid) begin
      accepted = 1; pend_addr = mem_req_addr;
      acc_log[acc_cnt % 4] = mem_req_addr; acc_cnt++;
    end
  end

  task automatic walk(input logic [9:0] d, input logic [9:0] t, input logic [11:0] off, input bit wr);
    logic [31:0] va = {d, t, off};
    logic [31:0] de, a0, a1, pe, exp_pa, hold_pa;
    logic [1:0]  exp_f, hold_f;
    int base_cnt, exp_n;
    de = root_word(d);
    a0 = root_base + {20'd0, d, 2'b00};
    a1 = {de[31:12], t, 2'b00};
    pe = leaf_word(a1);
    exp_pa = '0;
    if (!de[0]) begin exp_f = 2'd1; exp_n = 1; end
    else begin
      exp_n = 2;
      if (!pe[0]) exp_f = 2'd1;
      else if (wr && !pe[1]) exp_f = 2'd2;
      else begin exp_f = 2'd0; exp_pa = {pe[31:12], off}; end
    end
    base_cnt = acc_cnt;
    check(req_ready === 1'b1, "R8 idle ready", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    check(req_ready === 1'b0, "R8 busy not ready", {31'd0, req_ready}, 32'd0);
    req_vaddr = ~va; req_write = ~wr;
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    check(res_fault === exp_f, wr ? "R5 fault code write" : "R3 R4 fault code read", {30'd0, res_fault}, {30'd0, exp_f});
    check(res_paddr === exp_pa, "R6 physical address", res_paddr, exp_pa);
    check(acc_cnt - base_cnt == exp_n, exp_n == 1 ? "R3 single access" : "R11 two accesses",
          acc_cnt - base_cnt, exp_n);
    check(acc_log[base_cnt % 4] === a0, "R1 root read address", acc_log[base_cnt % 4], a0);
    if (exp_n == 2)
      check(acc_log[(base_cnt + 1) % 4] === a1, "R2 leaf read address", acc_log[(base_cnt + 1) % 4], a1);
    hold_pa = res_paddr; hold_f = res_fault;
    @(negedge clk); @(negedge clk);
    check(res_valid === 1'b1 && res_paddr === hold_pa && res_fault === hold_f, "R9 result held",
          res_paddr, hold_pa);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(req_ready === 1'b1 && res_valid === 1'b0, "R9 back to idle", {30'd0, req_ready, res_valid}, 32'd2);
  endtask

  initial begin
    #150_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    root_base = 32'h0003_0804;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1 && res_valid === 1'b0 && mem_req_valid === 1'b0, "R10 reset state",
          {29'd0, req_ready, res_valid, mem_req_valid}, 32'd4);
    for (int d = 0; d < 1024; d++) begin
      if (d == 512) root_base = 32'h0007_FFFC;
      walk(10'(d), 10'((d * 37 + 5) % 1024), 12'((d * 97) % 4096), 1'b0);
      walk(10'(d), 10'((d * 37 + 5) % 1024), 12'((d * 61 + 3) % 4096), 1'b1);
    end
    check(overlap == 0, "R7 single outstanding read", overlap, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule